// File: doc/BRIEF.md
# Modular Dot-Product Accelerator

This block computes a running dot product of two integer arrays, X and Y, that live in one memory with a single read port. A start strobe loads the element count, the modulus and the base addresses of both arrays. The block then steps the index i upward from zero. For each i it reads X[i] and then Y[i] on two consecutive cycles, keeps the first operand in a holding register, and updates the accumulator with the product truncated to the data width. When the new sum is greater than the modulus, the modulus is subtracted once before the value is stored.

The memory is assumed to answer in the same cycle as the address (zero read latency), so a run of N elements takes 2N access cycles. A one-cycle completion pulse follows the last update. The result stays on its port until the next accepted start. A count of zero finishes at once, with no memory access and a zero result. Addresses are word addresses.

Top module: `moddot_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0, `mem_rd` is 0 and `result` is 0.
- R2: A `start` seen while the block is idle clears the accumulator to zero and captures `len`, `modulus`, `base_x` and `base_y` for the run.
- R3: For each index i, counting up from 0, the block reads address `base_x + i` in one cycle and `base_y + i` in the next cycle, with `mem_rd` at 1 in both cycles.
- R4: Each update adds the product X[i]*Y[i], truncated to the low DATA_W bits, to the accumulator, with the sum wrapping modulo 2^DATA_W.
- R5: If that sum is greater than the captured modulus (a signed two's-complement compare when SIGNED_CMP=1, the default), the modulus is subtracted exactly once before the result is stored.
- R6: A run with N>0 elements keeps `mem_rd` at 1 for exactly 2N consecutive cycles, beginning in the cycle after the accepted start.
- R7: `done` is 1 for exactly one cycle, in the cycle right after the last update, and it shows the final result in that cycle. `result` then holds its value until the next accepted start.
- R8: A start with `len` = 0 raises `done` in the next cycle, issues no read, and gives a result of 0.
- R9: A `start` that arrives while a run is in progress is ignored, and the run goes on unchanged.
- R10: Changes to `len`, `modulus`, `base_x` or `base_y` after the start has been accepted have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| len | input | CNT_W | Element count N |
| modulus | input | DATA_W | Value K subtracted when the sum exceeds it |
| base_x | input | ADDR_W | Word address of X[0] |
| base_y | input | ADDR_W | Word address of Y[0] |
| mem_rd | output | 1 | Read strobe for the memory |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rdata | input | DATA_W | Read data, valid in the same cycle as the address |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Accumulated value S |

## Verification
The operand capture and the accumulator update can collide with a fresh start request: a start strobe may arrive in the same cycle as a read of X or of Y. The bench provokes this by pulsing `start` in the middle of a run, and in the same stretch it drives new count, modulus and base values. It then checks that the whole address sequence, the total of 2N read cycles and the final result match the model of the original run. A second collision happens in the last read cycle of a run, where the final update and the completion pulse are produced from the same cycle. The bench judges it by sampling `done` and `result` together in the following cycle.

// File: rtl/moddot_pkg.sv
package moddot_pkg;

   typedef enum logic [1:0] {
      MD_IDLE   = 2'd0,
      MD_FETCH1 = 2'd1,
      MD_FETCH2 = 2'd2
   } md_state_e;

endpackage

// File: rtl/moddot_ctrl.sv
module moddot_ctrl
   import moddot_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_in,
   output logic             accept,
   output logic             busy,
   output logic             second,
   output logic             cap_en,
   output logic             upd_en,
   output logic [CNT_W-1:0] idx,
   output logic [CNT_W-1:0] len_q,
   output logic             done
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   md_state_e        state_q;
   logic             last_elem;

   assign busy      = (state_q != MD_IDLE);
   assign accept    = start && !busy;
   assign second    = (state_q == MD_FETCH2);
   assign cap_en    = (state_q == MD_FETCH1);
   assign upd_en    = second;
   assign last_elem = (idx == (len_q - ONE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= MD_IDLE;
         idx     <= '0;
         len_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            MD_IDLE: begin
               if (accept) begin
                  len_q <= len_in;
                  idx   <= '0;
                  if (len_in == '0) begin
                     done <= 1'b1;
                  end else begin
                     state_q <= MD_FETCH1;
                  end
               end
            end
            MD_FETCH1: begin
               state_q <= MD_FETCH2;
            end
            MD_FETCH2: begin
               if (last_elem) begin
                  state_q <= MD_IDLE;
                  done    <= 1'b1;
               end else begin
                  idx     <= idx + ONE;
                  state_q <= MD_FETCH1;
               end
            end
            default: state_q <= MD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/moddot_agu.sv
module moddot_agu #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base1_in,
   input  logic [ADDR_W-1:0] base2_in,
   input  logic [CNT_W-1:0]  idx,
   input  logic              sel2,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] base1_q;
   logic [ADDR_W-1:0] base2_q;
   logic [ADDR_W-1:0] offs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base1_q <= '0;
         base2_q <= '0;
      end else if (load) begin
         base1_q <= base1_in;
         base2_q <= base2_in;
      end
   end

   generate
      if (CNT_W == ADDR_W) begin : g_same_w
         assign offs = idx;
      end else begin : g_ext_w
         assign offs = {{(ADDR_W-CNT_W){1'b0}}, idx};
      end
   endgenerate

   assign addr = (sel2 ? base2_q : base1_q) + offs;

endmodule

// File: rtl/moddot_mac.sv
module moddot_mac #(
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [DATA_W-1:0] k_in,
   input  logic              cap_en,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] acc
);

   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] k_q;
   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] nxt;
   logic              over;

   assign prod = opnd_q * rdata;
   assign sum  = acc + prod;

   generate
      if (SIGNED_CMP) begin : g_scmp
         assign over = ($signed(sum) > $signed(k_q));
      end else begin : g_ucmp
         assign over = (sum > k_q);
      end
   endgenerate

   assign nxt = over ? (sum - k_q) : sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opnd_q <= '0;
         k_q    <= '0;
         acc    <= '0;
      end else begin
         if (clr) begin
            acc <= '0;
            k_q <= k_in;
         end else if (upd_en) begin
            acc <= nxt;
         end
         if (cap_en) begin
            opnd_q <= rdata;
         end
      end
   end

endmodule

// File: rtl/moddot_engine.sv
module moddot_engine #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  len,
   input  logic [DATA_W-1:0] modulus,
   input  logic [ADDR_W-1:0] base_x,
   input  logic [ADDR_W-1:0] base_y,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data_w
         $error("moddot_engine: DATA_W must lie in 8..64");
      end
      if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt_w
         $error("moddot_engine: CNT_W must lie in 1..ADDR_W");
      end
   endgenerate

   logic             accept;
   logic             st_busy;
   logic             st_second;
   logic             cap_en;
   logic             upd_en;
   logic [CNT_W-1:0] st_idx;
   logic [CNT_W-1:0] st_len;

   moddot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .len_in (len),
      .accept (accept),
      .busy   (st_busy),
      .second (st_second),
      .cap_en (cap_en),
      .upd_en (upd_en),
      .idx    (st_idx),
      .len_q  (st_len),
      .done   (done)
   );

   moddot_agu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_agu (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .base1_in (base_x),
      .base2_in (base_y),
      .idx      (st_idx),
      .sel2     (st_second),
      .addr     (mem_addr)
   );

   moddot_mac #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .k_in   (modulus),
      .cap_en (cap_en),
      .upd_en (upd_en),
      .rdata  (mem_rdata),
      .acc    (result)
   );

   assign mem_rd = st_busy;

endmodule

// File: rtl/moddot_engine_chk.sv
module moddot_engine_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  len,
   input logic              mem_rd,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic              st_busy,
   input logic              st_second,
   input logic [CNT_W-1:0]  st_idx,
   input logic [CNT_W-1:0]  st_len
);

   // R3: a read of X is always followed by the matching read of Y
   p_pair_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !st_second) |=> (mem_rd && st_second));

   // R3: the index moves up by one between pairs
   p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !st_second && st_idx != '0) |-> ($past(st_second) && st_idx == $past(st_idx) + 1'b1));

   // R6: the index never reaches the captured count
   p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_busy |-> (st_idx < st_len));

   // R7: the completion pulse lasts one cycle unless restarted
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R7: the result holds while no read and no start occur
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd && !start) |=> $stable(result));

   // R8: a zero count finishes at once with a zero result
   p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !st_busy && len == '0) |=> (done && !mem_rd && result == '0));

   // R9: a start during the first read of a pair does not disturb the pair
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && st_busy && !st_second) |=> (st_busy && st_second));

endmodule

bind moddot_engine moddot_engine_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .len       (len),
   .mem_rd    (mem_rd),
   .done      (done),
   .result    (result),
   .st_busy   (st_busy),
   .st_second (st_second),
   .st_idx    (st_idx),
   .st_len    (st_len)
);

// File: tb/moddot_engine_tb.sv
`timescale 1ns/1ps
module moddot_engine_tb;

   localparam int DW = 32;
   localparam int AW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] len = '0;
   logic [DW-1:0] modulus = '0;
   logic [AW-1:0] base_x = '0;
   logic [AW-1:0] base_y = '0;
   logic          mem_rd;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic          done;
   logic [DW-1:0] result;

   logic [DW-1:0] mem [0:63];
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   assign mem_rdata = mem[mem_addr[5:0]];

   moddot_engine #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .SIGNED_CMP(1'b1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .len       (len),
      .modulus   (modulus),
      .base_x    (base_x),
      .base_y    (base_y),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .done      (done),
      .result    (result)
   );

   // {len, K, base_x, base_y}
   localparam logic [79:0] VEC [0:5] = '{
      {16'd4,  32'd100,        16'd0,  16'd8},
      {16'd1,  32'h7FFF_FFFF,  16'd3,  16'd9},
      {16'd8,  32'h7FFF_FFFF,  16'd10, 16'd30},
      {16'd6,  32'hFFFF_FFFB,  16'd5,  16'd40},
      {16'd12, 32'd0,          16'd20, 16'd44},
      {16'd16, 32'd1000000,    16'd2,  16'd33}
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model(input int n, input logic [DW-1:0] k,
                                           input int bx, input int by);
      logic [DW-1:0] s = '0;
      logic [DW-1:0] t;
      for (int i = 0; i < n; i++) begin
         t = s + mem[6'(bx + i)] * mem[6'(by + i)];
         if ($signed(t) > $signed(k)) t = t - k;
         s = t;
      end
      return s;
   endfunction

   // drives a run and checks sequence, cycle count, pulse and result
   task automatic run_op(input int n, input logic [DW-1:0] k, input int bx,
                         input int by, input bit disturb);
      logic [DW-1:0] exp;
      int seq_bad = 0;
      exp = model(n, k, bx, by);
      @(negedge clk);
      len = CW'(n); modulus = k; base_x = AW'(bx); base_y = AW'(by);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 2 * n; c++) begin
         if (mem_rd !== 1'b1 || done !== 1'b0 ||
             mem_addr !== AW'(((c % 2) == 0 ? bx : by) + c / 2))
            seq_bad++;
         if (disturb && c == 1) begin
            // R9 R10: new start and new inputs mid-run
            start = 1'b1; len = 16'd3; modulus = 32'd5;
            base_x = 16'd50; base_y = 16'd60;
         end
         if (disturb && c == 2) start = 1'b0;
         @(negedge clk);
      end
      chk(disturb ? "R9" : "R3", "address/strobe sequence errors", 64'(seq_bad), 64'd0);
      chk("R6", "strobe low after 2N cycles", {63'd0, mem_rd}, 64'd0);
      chk(n == 0 ? "R8" : "R7", "done after last update", {63'd0, done}, 64'd1);
      chk(disturb ? "R10" : "R5", "result at done", 64'(result), 64'(exp));
      @(negedge clk);
      chk("R7", "done falls after one cycle", {63'd0, done}, 64'd0);
      chk("R7", "result holds", 64'(result), 64'(exp));
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++)
         mem[i] = (32'(i) * 32'h0135_79BD + 32'hE000_0123) ^ (32'(i) << 20);
      mem[7] = 32'h9000_0001;
      mem[8] = 32'h0000_0007;

      repeat (3) @(negedge clk);
      chk("R1", "done in reset", {63'd0, done}, 64'd0);
      chk("R1", "mem_rd in reset", {63'd0, mem_rd}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "result after reset", 64'(result), 64'd0);
      chk("R1", "done after reset", {63'd0, done}, 64'd0);

      // R4 R5 R3 R6 R7: vector walk
      for (int v = 0; v < 6; v++)
         run_op(int'(VEC[v][79:64]), VEC[v][63:32], int'(VEC[v][31:16]),
                int'(VEC[v][15:0]), 1'b0);

      // R4: truncation with a wrapping product, no subtraction
      run_op(2, 32'h7FFF_FFFF, 7, 7, 1'b0);

      // R8 R2: zero count clears the previous result
      chk("R2", "previous result nonzero", {63'd0, result != 0}, 64'd1);
      run_op(0, 32'd9, 0, 0, 1'b0);
      chk("R8", "zero-length result", 64'(result), 64'd0);

      // R9 R10: restart attempt and input change during a run
      run_op(10, 32'd12345, 4, 20, 1'b1);

      // R2: a new run after a disturbed one starts from zero
      run_op(3, 32'd100, 1, 2, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule